// File: doc/BRIEF.md
# Eight-Line Prioritising Interrupt Controller

This block gathers eight edge-sensitive interrupt request lines into one interrupt output to a processor. It keeps three 8-bit registers: a request register that latches rising edges, an in-service register for the levels now being handled, and a mask register. It compares the best unmasked request with the best in-service level and raises the interrupt output only when the request ranks higher. A single-cycle acknowledge strobe moves the winning request into service. On the cycle after the strobe, the 8-bit vector appears on the read data bus.

Software sets up the block through a byte-wide register port. The port has a chip select, read and write strobes, and a one-bit register select. An initialization sequence sets the vector base and the end-of-service mode. After that, operation words change the mask, end service on a level (optionally rotating priority), set the lowest-priority level directly, choose which register a plain read returns, or arm a one-shot poll read. A cascade configuration word is accepted during setup but has no further effect.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset, irq_out is 0 and rdata is 0x00. The block stays uninitialised until the setup sequence completes.
- R2: The setup sequence runs as follows. A write with reg_sel=0 and wdata[4]=1 starts setup: bit 1 = 1 means single mode and bit 1 = 0 means cascade mode. This write clears the mask, in-service and request registers, restores IR0 as highest priority and selects the request register for reads. The next reg_sel=1 write gives the vector base in wdata[7:3]. In cascade mode, one more reg_sel=1 write is accepted and ignored. The final reg_sel=1 write sets automatic end-of-service from wdata[1]. irq_out stays 0 until setup completes.
- R3: A request bit is set on a rising edge of its irq_in line and stays set until that level is acknowledged. A line held high does not set its bit again.
- R4: After setup, a reg_sel=1 write loads the mask, where bit i = 1 disables level i. A masked request stays latched but never raises irq_out. A reg_sel=1 read returns the mask.
- R5: irq_out is 1 in the cycle after the state holds an unmasked request that outranks every in-service level. Otherwise it is 0.
- R6: On irq_ack, the winning level moves from the request register to the in-service register, and rdata on the next cycle is {base, level}. If no request qualifies, rdata is {base, 3'b111} and no register changes.
- R7: With automatic end-of-service enabled, an acknowledge never sets an in-service bit.
- R8: A reg_sel=0 write with wdata[4:3]=00 is an end-of-service word, with its code in wdata[7:5] and level L in wdata[2:0]. Code 001 clears the highest-priority in-service bit. Code 011 clears in-service bit L.
- R9: Code 101 acts like 001 and also makes the cleared level the lowest priority. Code 111 acts like 011 and also makes L the lowest. Code 110 only makes L the lowest. Priority then runs cyclically upward from the lowest-priority level.
- R10: A reg_sel=0 write with wdata[4:3]=01 is a read-control word. If wdata[1]=1, wdata[0] selects the in-service (1) or request (0) register for reg_sel=0 reads. wdata[2]=1 arms a poll. The next reg_sel=0 read then returns {any unmasked request, 0000, its highest-priority level}, and later reads return the selected register again.
- R11: A read strobe with cs high updates rdata on the next cycle. With cs low, writes and reads have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Register port select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| reg_sel | input | 1 | Register select bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or vector, registered |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| irq_ack | input | 1 | Acknowledge strobe, one cycle |
| irq_out | output | 1 | Interrupt to the processor, registered |

## Verification
The hardest states to reach are the ones where priority has been rotated and service is nested: a pending request that ranks below an in-service level must hold irq_out low, and a late acknowledge in that state must return the fallback vector. The stimulus raises two lines together after priority has been rotated or set. It acknowledges one line, issues the rotating end-of-service words, and then acknowledges again while the remaining request is still outranked. A behavioural model follows every cycle of this, and hand-computed vectors and register reads pin down each step.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_BASE, ST_CASC, ST_MODE, ST_RUN
  } setup_st_t;

  localparam int SETUP_TAG_BIT = 4;
  localparam int SINGLE_BIT    = 1;
  localparam int AUTO_EOS_BIT  = 1;
  localparam int CTRL_KIND_BIT = 3;
  localparam int POLL_BIT      = 2;
  localparam int RSEL_VALID    = 1;
  localparam int RSEL_BIT      = 0;

  localparam logic [2:0] OP_END_TOP     = 3'b001;
  localparam logic [2:0] OP_END_LVL     = 3'b011;
  localparam logic [2:0] OP_END_TOP_ROT = 3'b101;
  localparam logic [2:0] OP_END_LVL_ROT = 3'b111;
  localparam logic [2:0] OP_SET_LOWEST  = 3'b110;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
)(
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] lowest,
  output logic          any,
  output logic [LW-1:0] lvl,
  output logic [LW-1:0] rank
);
  always_comb begin
    any  = 1'b0;
    lvl  = '0;
    rank = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec[lowest + LW'(k + 1)]) begin
        any  = 1'b1;
        lvl  = lowest + LW'(k + 1);
        rank = LW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int N = 8
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] lines,
  output logic [N-1:0] req
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      req  <= '0;
    end else begin
      prev <= lines;
      if (clr_all) req <= '0;
      else         req <= (req & ~clr_mask) | (lines & ~prev);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int DW    = 8,
  localparam int LW   = $clog2(N_IRQ),
  localparam int BW   = DW - LW
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             cs,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic             reg_sel,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             irq_ack,
  output logic             irq_out
);
  localparam logic [N_IRQ-1:0] BIT0 = 1;

  setup_st_t        st;
  logic [BW-1:0]    base;
  logic             single, aeoi, rsel_isr, poll_arm;
  logic [N_IRQ-1:0] irr, imr, isr, pend;
  logic [LW-1:0]    lowest;

  logic wr_go, rd_go, icw1_wr, hi_wr, ocw2_wr, ocw3_wr, running, ack_go, grant;
  logic          req_any, isr_any;
  logic [LW-1:0] req_lvl, req_rank, isr_lvl, isr_rank, wl, low_nxt;
  logic [N_IRQ-1:0] irr_clr, isr_set, isr_clr;
  logic          low_we;

  assign running = (st == ST_RUN);
  assign wr_go   = cs & wr_en;
  assign rd_go   = cs & rd_en;
  assign icw1_wr = wr_go & ~reg_sel & wdata[SETUP_TAG_BIT];
  assign hi_wr   = wr_go & reg_sel;
  assign ocw2_wr = wr_go & ~reg_sel & ~wdata[SETUP_TAG_BIT] & ~wdata[CTRL_KIND_BIT] & running;
  assign ocw3_wr = wr_go & ~reg_sel & ~wdata[SETUP_TAG_BIT] &  wdata[CTRL_KIND_BIT] & running;
  assign ack_go  = irq_ack & running;
  assign pend    = irr & ~imr;
  assign wl      = wdata[LW-1:0];

  irq_req_latch #(.N(N_IRQ)) u_latch (
    .clk(clk), .rst(rst), .clr_all(icw1_wr), .clr_mask(irr_clr),
    .lines(irq_in), .req(irr)
  );

  irq_prio_pick #(.N(N_IRQ)) u_pick_req (
    .vec(pend), .lowest(lowest), .any(req_any), .lvl(req_lvl), .rank(req_rank)
  );

  irq_prio_pick #(.N(N_IRQ)) u_pick_isr (
    .vec(isr), .lowest(lowest), .any(isr_any), .lvl(isr_lvl), .rank(isr_rank)
  );

  assign grant   = running & req_any & (~isr_any | (req_rank < isr_rank));
  assign irr_clr = (ack_go & grant) ? (BIT0 << req_lvl) : '0;
  assign isr_set = (ack_go & grant & ~aeoi) ? (BIT0 << req_lvl) : '0;

  always_comb begin
    isr_clr = '0;
    low_we  = 1'b0;
    low_nxt = lowest;
    if (ocw2_wr) begin
      case (wdata[DW-1 -: 3])
        OP_END_TOP:     if (isr_any) isr_clr = BIT0 << isr_lvl;
        OP_END_TOP_ROT: if (isr_any) begin
          isr_clr = BIT0 << isr_lvl;
          low_we  = 1'b1;
          low_nxt = isr_lvl;
        end
        OP_END_LVL:     isr_clr = BIT0 << wl;
        OP_END_LVL_ROT: begin
          isr_clr = BIT0 << wl;
          low_we  = 1'b1;
          low_nxt = wl;
        end
        OP_SET_LOWEST:  begin
          low_we  = 1'b1;
          low_nxt = wl;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      base     <= '0;
      single   <= 1'b0;
      aeoi     <= 1'b0;
      rsel_isr <= 1'b0;
      poll_arm <= 1'b0;
      imr      <= '0;
      isr      <= '0;
      lowest   <= LW'(N_IRQ - 1);
      irq_out  <= 1'b0;
      rdata    <= '0;
    end else begin
      irq_out <= grant;
      if (icw1_wr) begin
        st       <= ST_BASE;
        single   <= wdata[SINGLE_BIT];
        aeoi     <= 1'b0;
        rsel_isr <= 1'b0;
        poll_arm <= 1'b0;
        imr      <= '0;
        isr      <= '0;
        lowest   <= LW'(N_IRQ - 1);
      end else begin
        isr <= (isr & ~isr_clr) | isr_set;
        if (low_we) lowest <= low_nxt;
        if (ocw3_wr) begin
          if (wdata[RSEL_VALID]) rsel_isr <= wdata[RSEL_BIT];
          poll_arm <= wdata[POLL_BIT];
        end
        if (hi_wr) begin
          case (st)
            ST_BASE: begin
              base <= wdata[DW-1:LW];
              st   <= single ? ST_MODE : ST_CASC;
            end
            ST_CASC: st <= ST_MODE;
            ST_MODE: begin
              aeoi <= wdata[AUTO_EOS_BIT];
              st   <= ST_RUN;
            end
            ST_RUN:  imr <= wdata[N_IRQ-1:0];
            default: ;
          endcase
        end
      end
      if (ack_go) begin
        rdata <= grant ? {base, req_lvl} : {base, {LW{1'b1}}};
      end else if (rd_go) begin
        if (reg_sel)       rdata <= DW'(imr);
        else if (poll_arm) rdata <= {req_any, {(DW-1-LW){1'b0}}, req_lvl};
        else if (rsel_isr) rdata <= DW'(isr);
        else               rdata <= DW'(irr);
        if (!reg_sel) poll_arm <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_IRQ = 8,
  parameter int DW    = 8
)(
  input logic             clk,
  input logic             rst,
  input logic             cs,
  input logic             wr_en,
  input logic             irq_ack,
  input logic             irq_out,
  input logic [DW-1:0]    rdata,
  input logic [N_IRQ-1:0] irr,
  input logic [N_IRQ-1:0] imr,
  input logic [N_IRQ-1:0] isr,
  input logic             grant,
  input logic             aeoi,
  input logic             running
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_out && rdata == '0));

  // R2
  a_r2_setup_silent: assert property (@(posedge clk) disable iff (rst)
    !running |=> !irq_out);

  // R5
  a_r5_out_needs_request: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|(irr & ~imr)));

  // R6
  a_r6_ack_adds_one: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && grant && !aeoi && !(cs && wr_en)) |=>
      ($countones(isr) == $countones($past(isr)) + 1));

  // R7
  a_r7_auto_no_service: assert property (@(posedge clk) disable iff (rst)
    aeoi |-> (isr == '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_IRQ(N_IRQ), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .wr_en(wr_en), .irq_ack(irq_ack),
  .irq_out(irq_out), .rdata(rdata), .irr(irr), .imr(imr), .isr(isr),
  .grant(grant), .aeoi(aeoi), .running(running)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rd_en = 1'b0, wr_en = 1'b0, reg_sel = 1'b0, irq_ack = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [7:0] rdata;
  logic       irq_out;
  int         errors = 0, checks = 0, cyc = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .cs(cs), .rd_en(rd_en), .wr_en(wr_en),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata), .irq_in(irq_in),
    .irq_ack(irq_ack), .irq_out(irq_out)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [7:0] m_irr, m_isr, m_imr, m_prev, m_rdata, t_pend, t_rise, t_set, t_clr, t_iclr;
  int  m_st, m_base, m_low, rl, rr, il, ir;
  bit  m_single, m_aeoi, m_rsel, m_poll, m_int, ra, ia, gr, wgo, rgo, ic1, oc2, oc3;

  function automatic bit pick(input bit [7:0] v, input int low, output int lvl, output int rank);
    bit f = 1'b0;
    lvl = 0; rank = 0;
    for (int r = 0; r < 8; r++) begin
      if (!f && v[(low + 1 + r) % 8]) begin
        f = 1'b1; lvl = (low + 1 + r) % 8; rank = r;
      end
    end
    return f;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_irr = 0; m_isr = 0; m_imr = 0; m_prev = 0; m_rdata = 0;
      m_st = 0; m_base = 0; m_low = 7; m_single = 0; m_aeoi = 0;
      m_rsel = 0; m_poll = 0; m_int = 0;
    end else begin
      wgo = cs && wr_en; rgo = cs && rd_en;
      ic1 = wgo && !reg_sel && wdata[4];
      oc2 = wgo && !reg_sel && !wdata[4] && !wdata[3] && m_st == 4;
      oc3 = wgo && !reg_sel && !wdata[4] && wdata[3] && m_st == 4;
      t_pend = m_irr & ~m_imr;
      ra = pick(t_pend, m_low, rl, rr);
      ia = pick(m_isr, m_low, il, ir);
      gr = (m_st == 4) && ra && (!ia || rr < ir);
      t_set = 0; t_iclr = 0; t_clr = 0;
      if (irq_ack && m_st == 4) begin
        m_rdata = gr ? 8'(m_base * 8 + rl) : 8'(m_base * 8 + 7);
        if (gr) begin
          t_iclr = 8'(1 << rl);
          if (!m_aeoi) t_set = 8'(1 << rl);
        end
      end else if (rgo) begin
        if (reg_sel) m_rdata = m_imr;
        else begin
          if (m_poll) m_rdata = ra ? 8'(8'h80 + rl) : 8'h00;
          else        m_rdata = m_rsel ? m_isr : m_irr;
          m_poll = 0;
        end
      end
      if (oc2) begin
        case (wdata[7:5])
          3'b001: if (ia) t_clr = 8'(1 << il);
          3'b101: if (ia) begin t_clr = 8'(1 << il); m_low = il; end
          3'b011: t_clr = 8'(1 << wdata[2:0]);
          3'b111: begin t_clr = 8'(1 << wdata[2:0]); m_low = wdata[2:0]; end
          3'b110: m_low = wdata[2:0];
          default: ;
        endcase
      end
      t_rise = irq_in & ~m_prev;
      m_prev = irq_in;
      m_int  = gr;
      if (ic1) begin
        m_irr = 0; m_isr = 0; m_imr = 0; m_low = 7; m_aeoi = 0;
        m_rsel = 0; m_poll = 0; m_single = wdata[1]; m_st = 1;
      end else begin
        m_irr = (m_irr & ~t_iclr) | t_rise;
        m_isr = (m_isr & ~t_clr) | t_set;
        if (oc3) begin
          if (wdata[1]) m_rsel = wdata[0];
          m_poll = wdata[2];
        end
        if (wgo && reg_sel) begin
          case (m_st)
            1: begin m_base = wdata[7:3]; m_st = m_single ? 3 : 2; end
            2: m_st = 3;
            3: begin m_aeoi = wdata[1]; m_st = 4; end
            4: m_imr = wdata;
            default: ;
          endcase
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check({7'd0, irq_out}, {7'd0, m_int}, "R5 irq_out vs model");
      check(rdata, m_rdata, "R11 rdata vs model");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr_en = 1; reg_sel = a; wdata = d;
    @(negedge clk); cs = 0; wr_en = 0;
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk); cs = 1; rd_en = 1; reg_sel = a;
    @(negedge clk); cs = 0; rd_en = 0;
    check(rdata, exp, tag);
  endtask

  task automatic ack_chk(input logic [7:0] exp, input string tag);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    check(rdata, exp, tag);
  endtask

  task automatic lines(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    idle(2);
  endtask

  task automatic out_chk(input logic exp, input string tag);
    check({7'd0, irq_out}, {7'd0, exp}, tag);
  endtask

  initial begin
    idle(4);
    rst = 0;
    @(negedge clk);
    out_chk(0, "R1 irq_out after reset");
    check(rdata, 8'h00, "R1 rdata after reset");
    lines(8'h04);
    out_chk(0, "R2 silent before setup");
    lines(8'h00);

    // single mode, base 0x20, normal end-of-service
    wr(0, 8'h13); wr(1, 8'h20); wr(1, 8'h01);
    rd_chk(1, 8'h00, "R2 mask cleared by setup");

    lines(8'h20);
    out_chk(1, "R5 request raises irq_out");
    ack_chk(8'h25, "R6 vector level 5");
    idle(1);
    out_chk(0, "R5 drops after ack");
    wr(0, 8'h0B);
    rd_chk(0, 8'h20, "R6 in-service bit 5");
    wr(0, 8'h0A);
    rd_chk(0, 8'h00, "R3 held line not relatched");

    lines(8'h62);
    out_chk(1, "R5 higher level nests");
    ack_chk(8'h21, "R6 vector level 1");
    idle(1);
    out_chk(0, "R5 lower request held off");

    wr(0, 8'h20);
    wr(0, 8'h0B);
    rd_chk(0, 8'h20, "R8 non-specific clears level 1");
    wr(0, 8'h65);
    rd_chk(0, 8'h00, "R8 specific clears level 5");
    out_chk(1, "R5 level 6 now wins");

    wr(1, 8'h40);
    idle(1);
    out_chk(0, "R4 masked request silent");
    rd_chk(1, 8'h40, "R4 mask readback");
    wr(1, 8'h00);
    idle(1);
    out_chk(1, "R4 unmask restores request");
    ack_chk(8'h26, "R6 vector level 6");
    wr(0, 8'hE6);
    rd_chk(0, 8'h00, "R9 specific rotate clears level 6");

    lines(8'h00);
    lines(8'h81);
    out_chk(1, "R9 request after rotation");
    ack_chk(8'h27, "R9 level 7 ranks first after rotation");
    idle(1);
    out_chk(0, "R9 level 0 below level 7");
    wr(0, 8'hA0);
    idle(1);
    out_chk(1, "R9 rotate on non-specific frees level 0");
    ack_chk(8'h20, "R9 level 0 served");
    wr(0, 8'h20);
    rd_chk(0, 8'h00, "R8 service cleared");

    wr(0, 8'hC3);
    lines(8'h00);
    lines(8'h14);
    wr(0, 8'h0C);
    rd_chk(0, 8'h84, "R10 poll byte level 4");
    rd_chk(0, 8'h00, "R10 poll is one-shot");
    ack_chk(8'h24, "R9 set-lowest makes level 4 first");
    idle(1);
    out_chk(0, "R5 level 2 outranked");
    ack_chk(8'h27, "R6 fallback vector");
    rd_chk(0, 8'h10, "R6 fallback leaves service");
    wr(0, 8'h20);
    idle(1);
    out_chk(1, "R8 level 2 free after end");

    @(negedge clk); wr_en = 1; reg_sel = 1; wdata = 8'hFF; cs = 0;
    @(negedge clk); wr_en = 0;
    rd_chk(1, 8'h00, "R11 write without cs ignored");

    // cascade mode, base 0x48, automatic end-of-service
    wr(0, 8'h11); wr(1, 8'h48); wr(1, 8'h04); wr(1, 8'h03);
    rd_chk(1, 8'h00, "R2 cascade word consumed");
    out_chk(0, "R2 request register cleared");
    lines(8'h00);
    lines(8'h08);
    out_chk(1, "R5 request after re-setup");
    ack_chk(8'h4B, "R2 new base in vector");
    wr(0, 8'h0B);
    rd_chk(0, 8'h00, "R7 auto mode leaves no service bit");
    out_chk(0, "R7 no request left");
    wr(0, 8'h0C);
    rd_chk(0, 8'h00, "R10 poll with nothing pending");

    idle(3);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule